// File: doc/BRIEF.md
# SPI Register Access Slave

This block lets an external SPI master read and write a bank of 64 byte-wide registers. A frame opens when the master pulls chip select low and closes when chip select returns high. The first byte of a frame is a command that gives the direction and a register address. Each later byte carries data. For a write, the master supplies the data. For a read, the block returns the addressed register. All bits travel most significant first.

Two wiring modes are available. In 4-wire mode, data arrives on a dedicated input pin and leaves on a dedicated output pin. In 3-wire mode, one shared half-duplex line carries both directions: its input path feeds the receiver, and its driver is enabled only while read data is sent. The serial pins are oversampled in the system clock domain, and the internal register file is reached through a plain address, write data, write strobe and read data port.

Top module: `sreg_spi_slave`

## Requirements
- R1: While chip select (`csn`) is high, SCK and data activity cause no register write and no output enable, and the first byte of the next frame is parsed as a command.
- R2: The block changes its serial output only after a falling SCK edge and holds it through the following high phase, so the master can sample it on the rising edge.
- R3: Command byte fields: bit 7 is the direction (1 = write, 0 = read), bits 6..1 are the register address, and bit 0 is ignored.
- R4: In a write frame, the 8 bits after the command are presented on `rf_wdata` with a single-cycle `rf_we` pulse, once all 8 bits have arrived. `rf_addr` is steady during the pulse.
- R5: In a read frame, the addressed register's contents are shifted out most significant bit first, during the byte after the command.
- R6: In frames with more than one data byte, the address advances by one after each data byte and wraps from 63 to 0.
- R7: A frame that ends before the eighth bit of a data byte causes no write for that byte.
- R8: With `mode_3w` low, input is taken from `sdi`, output goes to `sdo`, and `sdo_oe` is high only during read data bytes. It is never high in a write frame.
- R9: With `mode_3w` high, input is taken from `sdio_i` and output goes to `sdio_o`. `sdio_oe` is high only during read data bytes, and `sdo_oe` stays low.
- R10: After reset, and whenever `csn` is high, both output enables are low and `rf_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| mode_3w | input | 1 | 1 = shared half-duplex line, 0 = separate in/out lines |
| sck | input | 1 | Serial clock from the master |
| csn | input | 1 | Active-low frame select |
| sdi | input | 1 | Dedicated serial input (4-wire mode) |
| sdio_i | input | 1 | Input path of the shared line (3-wire mode) |
| rf_rdata | input | 8 | Register file read data for `rf_addr` |
| sdo | output | 1 | Dedicated serial output (4-wire mode) |
| sdo_oe | output | 1 | Driver enable for `sdo` |
| sdio_o | output | 1 | Output path of the shared line (3-wire mode) |
| sdio_oe | output | 1 | Driver enable for the shared line |
| rf_addr | output | 6 | Register file address |
| rf_wdata | output | 8 | Register file write data |
| rf_we | output | 1 | Single-cycle write strobe |

## Verification
Directed frames cover four cases: a single-byte write and read-back, a three-byte burst starting at address 62 (which separates wrapping from stopping or overflowing), a write aborted after five data bits, and SCK toggling with chip select high. Together these separate a correct address step and strobe placement from off-by-one counting and late strobes. Seeded random frames then mix mode, direction, address, burst length and the ignored command bit. On every bit, the unused input pin is fed noise, so a mode that takes data from the wrong pin is exposed. The bench checks output enables on every bit, and checks that read data holds through the high SCK phase, which tells falling-edge launch apart from rising-edge launch.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    localparam int SREG_AW    = 6;
    localparam int SREG_DW    = 8;
    localparam int SREG_SYNC  = 2;

    typedef enum logic {
        PH_CMD  = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    typedef struct packed {
        logic               wr;
        logic [SREG_AW-1:0] addr;
    } cmd_t;

    typedef struct packed {
        logic sel_n;
        logic rise;
        logic fall;
        logic din;
    } sev_t;

    // Command fields: top bit direction, then the address; lowest bit ignored.
    function automatic cmd_t decode_cmd(input logic [SREG_DW-1:1] hi);
        cmd_t c;
        c.wr   = hi[SREG_DW-1];
        c.addr = hi[SREG_DW-2:1];
        return c;
    endfunction

endpackage

// File: rtl/sreg_sync.sv
module sreg_sync
    import sreg_pkg::*;
#(
    parameter int STAGES = SREG_SYNC
) (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic csn,
    input  logic din,
    output sev_t ev
);

    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] sck_p;
    logic [STAGES-1:0] csn_p;
    logic [STAGES-1:0] din_p;
    logic              sck_d;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) begin
                    sck_p <= '0;
                    csn_p <= '1;
                    din_p <= '0;
                end else begin
                    sck_p <= sck;
                    csn_p <= csn;
                    din_p <= din;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) begin
                    sck_p <= '0;
                    csn_p <= '1;
                    din_p <= '0;
                end else begin
                    sck_p <= {sck_p[STAGES-2:0], sck};
                    csn_p <= {csn_p[STAGES-2:0], csn};
                    din_p <= {din_p[STAGES-2:0], din};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_d <= 1'b0;
        end else begin
            sck_d <= sck_p[TOP];
        end
    end

    always_comb begin
        ev.sel_n = csn_p[TOP];
        ev.rise  = ~csn_p[TOP] &  sck_p[TOP] & ~sck_d;
        ev.fall  = ~csn_p[TOP] & ~sck_p[TOP] &  sck_d;
        ev.din   = din_p[TOP];
    end

endmodule

// File: rtl/sreg_frame.sv
module sreg_frame
    import sreg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  sev_t               ev,
    output logic [SREG_AW-1:0] rf_addr,
    output logic [SREG_DW-1:0] rf_wdata,
    output logic               rf_we,
    output logic               rd_phase,
    output logic               byte_edge
);

    localparam int CNT_W = $clog2(SREG_DW);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SREG_DW - 1);

    phase_e             phase;
    logic [CNT_W-1:0]   bit_cnt;
    logic [SREG_DW-1:0] shreg;
    logic               dir_wr;
    logic               inc_pend;
    logic [SREG_DW-1:0] next_byte;
    cmd_t               cmd_now;

    assign next_byte = {shreg[SREG_DW-2:0], ev.din};
    assign cmd_now   = decode_cmd(next_byte[SREG_DW-1:1]);

    always_ff @(posedge clk) begin
        if (rst || ev.sel_n) begin
            phase    <= PH_CMD;
            bit_cnt  <= '0;
            shreg    <= '0;
            dir_wr   <= 1'b0;
            rf_addr  <= '0;
            rf_wdata <= '0;
            rf_we    <= 1'b0;
            inc_pend <= 1'b0;
        end else begin
            rf_we    <= 1'b0;
            inc_pend <= 1'b0;
            if (inc_pend) begin
                rf_addr <= rf_addr + 1'b1;
            end
            if (ev.rise) begin
                shreg   <= next_byte;
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == LAST_BIT) begin
                    if (phase == PH_CMD) begin
                        dir_wr  <= cmd_now.wr;
                        rf_addr <= cmd_now.addr;
                        phase   <= PH_DATA;
                    end else begin
                        if (dir_wr) begin
                            rf_we    <= 1'b1;
                            rf_wdata <= next_byte;
                        end
                        inc_pend <= 1'b1;
                    end
                end
            end
        end
    end

    assign rd_phase  = (phase == PH_DATA) && !dir_wr;
    assign byte_edge = (bit_cnt == '0);

endmodule

// File: rtl/sreg_tx.sv
module sreg_tx
    import sreg_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  sev_t               ev,
    input  logic               rd_phase,
    input  logic               byte_edge,
    input  logic [SREG_DW-1:0] rf_rdata,
    output logic               tx_bit,
    output logic               tx_valid
);

    logic [SREG_DW-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst || ev.sel_n) begin
            sh       <= '0;
            tx_valid <= 1'b0;
        end else if (ev.fall && rd_phase && byte_edge) begin
            sh       <= rf_rdata;
            tx_valid <= 1'b1;
        end else if (ev.fall && tx_valid) begin
            sh <= {sh[SREG_DW-2:0], 1'b0};
        end
    end

    assign tx_bit = sh[SREG_DW-1];

endmodule

// File: rtl/sreg_spi_slave.sv
module sreg_spi_slave
    import sreg_pkg::*;
#(
    parameter int AW     = SREG_AW,
    parameter int DW     = SREG_DW,
    parameter int STAGES = SREG_SYNC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          mode_3w,
    input  logic          sck,
    input  logic          csn,
    input  logic          sdi,
    input  logic          sdio_i,
    input  logic [DW-1:0] rf_rdata,
    output logic          sdo,
    output logic          sdo_oe,
    output logic          sdio_o,
    output logic          sdio_oe,
    output logic [AW-1:0] rf_addr,
    output logic [DW-1:0] rf_wdata,
    output logic          rf_we
);

    sev_t ev;
    logic din_sel;
    logic rd_phase;
    logic byte_edge;
    logic tx_bit;
    logic tx_valid;

    assign din_sel = mode_3w ? sdio_i : sdi;

    sreg_sync #(.STAGES(STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .sck (sck),
        .csn (csn),
        .din (din_sel),
        .ev  (ev)
    );

    sreg_frame u_frame (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .rf_addr   (rf_addr),
        .rf_wdata  (rf_wdata),
        .rf_we     (rf_we),
        .rd_phase  (rd_phase),
        .byte_edge (byte_edge)
    );

    sreg_tx u_tx (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .rd_phase  (rd_phase),
        .byte_edge (byte_edge),
        .rf_rdata  (rf_rdata),
        .tx_bit    (tx_bit),
        .tx_valid  (tx_valid)
    );

    assign sdo     = tx_bit;
    assign sdio_o  = tx_bit;
    assign sdo_oe  = tx_valid & ~mode_3w & ~csn;
    assign sdio_oe = tx_valid &  mode_3w & ~csn;

endmodule

// File: rtl/sreg_spi_slave_chk.sv
module sreg_spi_slave_chk #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          sck,
    input logic          sdo,
    input logic          sdo_oe,
    input logic          sdio_oe,
    input logic          rf_we,
    input logic [AW-1:0] rf_addr
);

    // R4: the write strobe lasts exactly one cycle
    assert_we_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> !rf_we);

    // R4: the address is steady during the strobe
    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> $stable(rf_addr));

    // R8: a write frame never turns on an output driver
    assert_no_drive_on_write_R8: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> !(sdo_oe || sdio_oe));

    // R9: never both drivers at once
    assert_oe_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(sdo_oe && sdio_oe));

    // R2: a driven output changes only while SCK is low (SCK half period
    // assumed longer than the synchronizer latency)
    assert_fall_drive_R2: assert property (@(posedge clk) disable iff (rst)
        ((sdo_oe || sdio_oe) && $past(sdo_oe || sdio_oe) && !$stable(sdo)) |-> !sck);

endmodule

bind sreg_spi_slave sreg_spi_slave_chk #(.AW(AW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .sck     (sck),
    .sdo     (sdo),
    .sdo_oe  (sdo_oe),
    .sdio_oe (sdio_oe),
    .rf_we   (rf_we),
    .rf_addr (rf_addr)
);

// File: tb/sreg_spi_slave_tb.sv
module sreg_spi_slave_tb;

    localparam int HP = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_3w = 1'b0;
    logic       sck = 1'b0;
    logic       csn = 1'b1;
    logic       sdi = 1'b0;
    logic       sdio_i = 1'b0;
    logic [7:0] rf_rdata;
    logic       sdo, sdo_oe, sdio_o, sdio_oe;
    logic [5:0] rf_addr;
    logic [7:0] rf_wdata;
    logic       rf_we;

    logic [7:0] regs  [64];
    logic [7:0] model [64];
    logic [7:0] tx_buf [4];
    logic [7:0] rx_buf [4];
    int we_cnt = 0;
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    sreg_spi_slave u_dut (
        .clk(clk), .rst(rst), .mode_3w(mode_3w), .sck(sck), .csn(csn),
        .sdi(sdi), .sdio_i(sdio_i), .rf_rdata(rf_rdata),
        .sdo(sdo), .sdo_oe(sdo_oe), .sdio_o(sdio_o), .sdio_oe(sdio_oe),
        .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_we(rf_we)
    );

    // bench-side register file
    assign rf_rdata = regs[rf_addr];
    always @(posedge clk) begin
        if (rf_we) begin
            regs[rf_addr] <= rf_wdata;
            we_cnt <= we_cnt + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic half();
        repeat (HP) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Send bits tx[7] down to tx[8-nbits]; rd marks a read data byte.
    task automatic xfer(input logic [7:0] tx, input int nbits, input bit rd, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i >= 8 - nbits; i--) begin
            logic cur;
            sck = 1'b0;
            if (mode_3w) begin sdio_i = tx[i]; sdi = 1'($urandom); end
            else         begin sdi = tx[i]; sdio_i = 1'($urandom); end
            half();
            cur = mode_3w ? sdio_o : sdo;
            rx[i] = cur;
            chk(sdo_oe == (rd && !mode_3w), "R8 sdo_oe", sdo_oe, rd && !mode_3w);
            chk(sdio_oe == (rd && mode_3w), "R9 sdio_oe", sdio_oe, rd && mode_3w);
            sck = 1'b1;
            half();
            if (rd) chk((mode_3w ? sdio_o : sdo) == cur, "R2 hold through high phase",
                        mode_3w ? sdio_o : sdo, cur);
        end
    endtask

    task automatic run_frame(input bit wr, input logic [5:0] a, input int n, input bit pad, input string tag);
        logic [7:0] d;
        int we0;
        we0 = we_cnt;
        csn = 1'b0;
        half();
        xfer({wr, a, pad}, 8, 1'b0, d);
        for (int k = 0; k < n; k++) begin
            xfer(wr ? tx_buf[k] : 8'(($urandom)), 8, !wr, d);
            rx_buf[k] = d;
        end
        sck = 1'b0;
        half();
        csn = 1'b1;
        half();
        chk(sdo_oe == 1'b0 && sdio_oe == 1'b0, "R10 idle enables", {sdo_oe, sdio_oe}, 0);
        for (int k = 0; k < n; k++) begin
            logic [5:0] ix;
            ix = 6'(a + 6'(k));
            if (wr) begin
                model[ix] = tx_buf[k];
                chk(regs[ix] == model[ix], {tag, " R4 write data"}, regs[ix], model[ix]);
            end else begin
                chk(rx_buf[k] == model[ix], {tag, " R5 read data"}, rx_buf[k], model[ix]);
            end
        end
        chk(we_cnt - we0 == (wr ? n : 0), {tag, " R4 strobe count"}, we_cnt - we0, wr ? n : 0);
    endtask

    initial begin
        int unsigned sd;
        sd = $urandom(32'd4242);
        for (int i = 0; i < 64; i++) begin
            regs[i]  = 8'($urandom);
            model[i] = regs[i];
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!sdo_oe && !sdio_oe && !rf_we, "R10 reset state", {sdo_oe, sdio_oe, rf_we}, 0);

        // R1: activity with chip select high
        for (int i = 0; i < 16; i++) begin
            sck = ~sck; sdi = 1'($urandom); sdio_i = 1'($urandom);
            half();
            chk(!sdo_oe && !sdio_oe, "R1 enables with csn high", {sdo_oe, sdio_oe}, 0);
        end
        sck = 1'b0;
        half();
        chk(we_cnt == 0, "R1 no write with csn high", we_cnt, 0);

        // R3/R4/R8: single write, pad bit set, then read back
        mode_3w = 1'b0;
        tx_buf[0] = 8'hA5;
        run_frame(1'b1, 6'd5, 1, 1'b1, "R3 pad ignored");
        run_frame(1'b0, 6'd5, 1, 1'b0, "R5 4-wire readback");

        // R6: burst write and read across the wrap
        tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_buf[2] = 8'h33;
        run_frame(1'b1, 6'd62, 3, 1'b0, "R6 wrap write");
        chk(regs[0] == 8'h33, "R6 wrapped to 0", regs[0], 8'h33);
        run_frame(1'b0, 6'd63, 3, 1'b0, "R6 wrap read");

        // R7: aborted data byte
        begin
            logic [7:0] d;
            int we0;
            logic [7:0] keep;
            keep = regs[10];
            we0 = we_cnt;
            csn = 1'b0; half();
            xfer({1'b1, 6'd10, 1'b0}, 8, 1'b0, d);
            xfer(8'h5A, 5, 1'b0, d);
            sck = 1'b0; half();
            csn = 1'b1; half();
            chk(we_cnt == we0, "R7 no strobe on abort", we_cnt, we0);
            chk(regs[10] == keep, "R7 register kept", regs[10], keep);
        end

        // R9: 3-wire write and read
        mode_3w = 1'b1;
        tx_buf[0] = 8'h3C;
        run_frame(1'b1, 6'd33, 1, 1'b0, "R9 3-wire write");
        run_frame(1'b0, 6'd33, 1, 1'b1, "R9 3-wire read");

        // random frames
        for (int t = 0; t < 24; t++) begin
            int n;
            mode_3w = 1'($urandom);
            n = 1 + int'($urandom % 3);
            for (int k = 0; k < 4; k++) tx_buf[k] = 8'($urandom);
            run_frame(1'($urandom), 6'($urandom), n, 1'($urandom), "random R6");
        end

        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule